// File: doc/BRIEF.md
# Table Lookup Interpolation Unit

This unit computes a signed linear interpolation between two neighbouring sample values. A 16-bit selector word holds the interpolation request. Its upper byte is an entry index and its lower byte is an 8-bit fraction. In table mode the unit fetches the two samples at the index and at the next index through a synchronous memory read port. In register-pair mode the two samples arrive directly on input pins and no memory is read.

Operands are byte, word or long. The unit has two output forms. Rounded mode gives the interpolated value at operand scale, rounded half up. Unrounded mode keeps eight fraction bits below the integer part. Unrounded results can be chained. Two unrounded byte lookups on neighbouring table columns, fed to a rounded word register-pair interpolation with a second fraction, give a surface interpolation with no loss in the intermediate values. Word lookups chain the same way into a long second stage.

A caller pulses `start` while the unit is idle. It waits for the one-cycle `done` pulse and then reads `result`, which holds its value until the next completion.

Top module: `tbl_interp`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_rd` are 0 and `result` is 0.
- R2: In table mode, with index = selector[15:8] and size code s, the unit reads address base + (index << s) and then address base + ((index+1) << s), on two consecutive cycles, modulo 2^ADDR_W. `mem_rd` is high only in those two cycles. Read data appears on `mem_rdata` one cycle after its address.
- R3: Size codes are 2'b00 byte, 2'b01 word and 2'b10 long. Code 2'b11 acts as long. Both samples are sign-extended from bits [7:0], [15:0] or [31:0], and higher input bits are ignored.
- R4: In unrounded mode (`round_en`=0) the result is the 40-bit two's complement value A*256 + (B-A)*f. Here A and B are the extended samples and f = selector[7:0] is taken as unsigned.
- R5: In rounded mode (`round_en`=1) the result is (A*256 + (B-A)*f + 128) arithmetically shifted right by 8 and sign-extended to 40 bits. A rounded result always lies between A and B.
- R6: With f = 0 the result is exactly A in rounded mode and A*256 in unrounded mode, in both table mode and register-pair mode.
- R7: In register-pair mode (`tbl_mode`=0) the samples are `end_a` (A) and `end_b` (B) as captured at start. The memory is never read.
- R8: For a start sampled at clock edge k, `done` is high for exactly one cycle, starting at edge k+2 in register-pair mode or edge k+5 in table mode. `busy` is high from edge k+1 until `done` rises, and it is low while `done` is high.
- R9: A start while `busy` is high has no effect on the running operation or on its result.
- R10: In a surface chain, two unrounded byte lookups followed by a rounded word register-pair interpolation of those two results give the R5 value of those exact 16-bit inputs. The same holds for word lookups followed by a long stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| tbl_mode | input | 1 | 1: fetch samples from memory, 0: use end_a/end_b |
| round_en | input | 1 | 1: rounded result, 0: keep 8 fraction bits |
| op_size | input | 2 | Operand size code |
| selector | input | 16 | Entry index [15:8] and fraction [7:0] |
| tbl_base | input | ADDR_W | Table byte address of entry 0 |
| end_a | input | 32 | Lower sample in register-pair mode |
| end_b | input | 32 | Upper sample in register-pair mode |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 32 | Memory data, one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 40 | Signed interpolation result |

## Verification
The assertions assume that `mem_rdata` arrives exactly one cycle after a read and stays valid for that cycle. They also assume that `start` is raised only between clock edges and stays up for whole cycles. The bench memory model answers every read on the next edge. The bench drives all inputs at the falling edge and holds each start for one cycle. It fires its extra starts only while the unit is busy, so that the ignore rule can be observed through the result.

// File: rtl/tbl_interp_pkg.sv
package tbl_interp_pkg;

  localparam int DATA_W = 32;
  localparam int FRAC_W = 8;
  localparam int RES_W  = DATA_W + FRAC_W;
  localparam int ACC_W  = RES_W + 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } opsize_e;

  // sign extension of a raw operand according to its size code
  function automatic logic signed [DATA_W-1:0] sext_op(input logic [DATA_W-1:0] v,
                                                       input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return DATA_W'($signed(v[7:0]));
      SZ_WORD: return DATA_W'($signed(v[15:0]));
      default: return $signed(v);
    endcase
  endfunction

  // A*2^FRAC_W + (B-A)*f, exact
  function automatic logic signed [RES_W-1:0] lerp_scaled(input logic signed [DATA_W-1:0] a,
                                                          input logic signed [DATA_W-1:0] b,
                                                          input logic [FRAC_W-1:0] f);
    logic signed [ACC_W-1:0] ae, be, fe, sum;
    ae  = ACC_W'(a);
    be  = ACC_W'(b);
    fe  = ACC_W'($signed({1'b0, f}));
    sum = (ae <<< FRAC_W) + ((be - ae) * fe);
    return sum[RES_W-1:0];
  endfunction

  // half-up rounding of a scaled value back to integer scale
  function automatic logic signed [RES_W-1:0] round_scaled(input logic signed [RES_W-1:0] s);
    logic signed [RES_W-1:0] t;
    t = s + RES_W'(1 << (FRAC_W - 1));
    return t >>> FRAC_W;
  endfunction

endpackage

// File: rtl/tbl_addr_gen.sv
module tbl_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        sz,
  input  logic              upper,
  output logic [ADDR_W-1:0] addr
);
  localparam int STEP_W = IDX_W + 1;

  logic [STEP_W-1:0] entry;
  logic [1:0]        shamt;

  always_comb begin
    entry = {1'b0, idx} + STEP_W'(upper);
    shamt = (sz == 2'b11) ? 2'b10 : sz;
    addr  = base + (ADDR_W'(entry) << shamt);
  end
endmodule

// File: rtl/tbl_interp_dp.sv
module tbl_interp_dp
  import tbl_interp_pkg::*;
(
  input  logic [DATA_W-1:0] raw_a,
  input  logic [DATA_W-1:0] raw_b,
  input  logic [1:0]        sz,
  input  logic [FRAC_W-1:0] frac,
  input  logic              rnd,
  output logic [RES_W-1:0]  res
);
  logic signed [DATA_W-1:0] sa, sb;
  logic signed [RES_W-1:0]  scaled;

  always_comb begin
    sa     = sext_op(raw_a, sz);
    sb     = sext_op(raw_b, sz);
    scaled = lerp_scaled(sa, sb, frac);
    res    = rnd ? round_scaled(scaled) : scaled;
  end
endmodule

// File: rtl/tbl_interp_ctl.sv
module tbl_interp_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tbl_mode,
  output logic accept,
  output logic fetch_lo,
  output logic fetch_hi,
  output logic cap_lo,
  output logic cap_hi,
  output logic calc_fire,
  output logic busy
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_TAIL, ST_CALC
  } ctl_state_e;

  ctl_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start) state_nx = tbl_mode ? ST_RD_LO : ST_CALC;
      ST_RD_LO: state_nx = ST_RD_HI;
      ST_RD_HI: state_nx = ST_TAIL;
      ST_TAIL:  state_nx = ST_CALC;
      ST_CALC:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign accept    = start && (state == ST_IDLE);
  assign fetch_lo  = (state == ST_RD_LO);
  assign fetch_hi  = (state == ST_RD_HI);
  assign cap_lo    = (state == ST_RD_HI);
  assign cap_hi    = (state == ST_TAIL);
  assign calc_fire = (state == ST_CALC);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/tbl_interp.sv
module tbl_interp
  import tbl_interp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tbl_mode,
  input  logic              round_en,
  input  logic [1:0]        op_size,
  input  logic [IDX_W+FRAC_W-1:0] selector,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [DATA_W-1:0] end_a,
  input  logic [DATA_W-1:0] end_b,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  localparam int SEL_W = IDX_W + FRAC_W;

  // named events, also used by the checker
  logic accept, fetch_lo, fetch_hi, cap_lo, cap_hi, calc_fire;

  logic              mode_q, round_q;
  logic [1:0]        size_q;
  logic [IDX_W-1:0]  idx_q;
  logic [FRAC_W-1:0] frac_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [RES_W-1:0]  dp_res, result_q;
  logic              done_q;

  tbl_interp_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tbl_mode (tbl_mode),
    .accept   (accept),
    .fetch_lo (fetch_lo),
    .fetch_hi (fetch_hi),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .calc_fire(calc_fire),
    .busy     (busy)
  );

  tbl_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base (base_q),
    .idx  (idx_q),
    .sz   (size_q),
    .upper(fetch_hi),
    .addr (mem_addr)
  );

  tbl_interp_dp u_dp (
    .raw_a(a_q),
    .raw_b(b_q),
    .sz   (size_q),
    .frac (frac_q),
    .rnd  (round_q),
    .res  (dp_res)
  );

  assign mem_rd = fetch_lo | fetch_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      round_q <= 1'b0;
      size_q  <= 2'b00;
      idx_q   <= '0;
      frac_q  <= '0;
      base_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      if (accept) begin
        mode_q  <= tbl_mode;
        round_q <= round_en;
        size_q  <= op_size;
        idx_q   <= selector[SEL_W-1:FRAC_W];
        frac_q  <= selector[FRAC_W-1:0];
        base_q  <= tbl_base;
        if (!tbl_mode) begin
          a_q <= end_a;
          b_q <= end_b;
        end
      end
      if (cap_lo) a_q <= mem_rdata;
      if (cap_hi) b_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= calc_fire;
      if (calc_fire) result_q <= dp_res;
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/tbl_interp_chk.sv
module tbl_interp_chk
  import tbl_interp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fetch_hi,
  input logic              calc_fire,
  input logic              mode_q,
  input logic              round_q,
  input logic [1:0]        size_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [RES_W-1:0]  result
);
  logic signed [RES_W-1:0] ea, eb, lo_v, hi_v, zero_v;
  logic [1:0]              shamt;

  always_comb begin
    ea     = RES_W'(sext_op(a_q, size_q));
    eb     = RES_W'(sext_op(b_q, size_q));
    lo_v   = (ea < eb) ? ea : eb;
    hi_v   = (ea < eb) ? eb : ea;
    zero_v = round_q ? ea : (ea <<< FRAC_W);
    shamt  = (size_q == 2'b11) ? 2'b10 : size_q;
  end

  p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);

  p_hi_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hi |-> mem_rd && $past(mem_rd) &&
                 (mem_addr == $past(mem_addr) + (ADDR_W'(1) << shamt)));

  p_pair_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> !mem_rd);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_calc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    calc_fire |=> (done && !busy));

  p_round_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && round_q) |-> (($signed(result) >= lo_v) && ($signed(result) <= hi_v)));

  p_frac_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (frac_q == '0)) |-> ($signed(result) == zero_v));
endmodule

bind tbl_interp tbl_interp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .fetch_hi (fetch_hi),
  .calc_fire(calc_fire),
  .mode_q   (mode_q),
  .round_q  (round_q),
  .size_q   (size_q),
  .frac_q   (frac_q),
  .a_q      (a_q),
  .b_q      (b_q),
  .result   (result)
);

// File: tb/tbl_interp_test.sv
`timescale 1ns/1ps
module tbl_interp_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        tbl_mode = 1'b0;
  logic        round_en = 1'b0;
  logic [1:0]  op_size = 2'b00;
  logic [15:0] selector = '0;
  logic [15:0] tbl_base = '0;
  logic [31:0] end_a = '0, end_b = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        busy, done;
  logic [39:0] result;

  int total = 0, bad = 0;
  int cyc = 0;
  int start_cyc = -100, done_cyc = -100, rd_cyc = -100;
  logic [15:0] exp_ad0, exp_ad1;
  bit finished = 0;
  logic [7:0] tmem [0:255];

  always #2 clk = ~clk;   // 250 MHz

  tbl_interp uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_mode(tbl_mode),
    .round_en(round_en), .op_size(op_size), .selector(selector),
    .tbl_base(tbl_base), .end_a(end_a), .end_b(end_b),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] rd_word(input int addr);
    return {tmem[(addr+3) & 255], tmem[(addr+2) & 255],
            tmem[(addr+1) & 255], tmem[addr & 255]};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= rd_word(int'(mem_addr));
  end

  function automatic longint sx(input logic [31:0] v, input int sz);
    if (sz == 0) return longint'($signed(v[7:0]));
    if (sz == 1) return longint'($signed(v[15:0]));
    return longint'($signed(v));
  endfunction

  function automatic longint model(input longint a, input longint b, input int f, input bit rnd);
    longint s;
    s = a * 256 + (b - a) * f;
    if (rnd) return (s + 128) >>> 8;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint got, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d at cycle %0d", req, got, expv, cyc);
    end
  endtask

  // per-clock comparison of the control outputs against the timing model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_done, e_busy, e_rd;
      e_done = (cyc == done_cyc);
      e_busy = (cyc > start_cyc) && (cyc < done_cyc);
      e_rd   = (cyc == rd_cyc) || (cyc == rd_cyc + 1);
      chk(done === e_done, "R8 done", longint'(done), longint'(e_done));
      chk(busy === e_busy, "R8 busy", longint'(busy), longint'(e_busy));
      chk(mem_rd === e_rd, "R2/R7 mem_rd", longint'(mem_rd), longint'(e_rd));
      if (cyc == rd_cyc)
        chk(mem_addr === exp_ad0, "R2 first address", longint'(mem_addr), longint'(exp_ad0));
      if (cyc == rd_cyc + 1)
        chk(mem_addr === exp_ad1, "R2 second address", longint'(mem_addr), longint'(exp_ad1));
    end
  end

  // one operation; called at a falling edge, returns at a falling edge
  task automatic run_op(input string req, input bit tm, input bit rnd, input int sz,
                        input logic [15:0] sel, input logic [15:0] base,
                        input logic [31:0] ea, input logic [31:0] eb,
                        input bit poke, output longint got);
    longint a, b, expv;
    int sh, idx;
    sh  = (sz == 3) ? 2 : sz;
    idx = int'(sel[15:8]);
    exp_ad0 = base + 16'(idx << sh);
    exp_ad1 = base + 16'((idx + 1) << sh);
    if (tm) begin
      a = sx(rd_word(int'(exp_ad0)), sh);
      b = sx(rd_word(int'(exp_ad1)), sh);
    end else begin
      a = sx(ea, sh);
      b = sx(eb, sh);
    end
    expv = model(a, b, int'(sel[7:0]), rnd);
    tbl_mode = tm; round_en = rnd; op_size = 2'(sz);
    selector = sel; tbl_base = base; end_a = ea; end_b = eb;
    start = 1'b1;
    start_cyc = cyc;
    done_cyc  = cyc + (tm ? 5 : 2);
    rd_cyc    = tm ? cyc + 1 : -100;
    @(negedge clk);
    if (poke) begin
      // R9: a second request during busy must be ignored
      end_a = ~ea; end_b = ~eb; selector = ~sel; tbl_mode = ~tm; round_en = ~rnd;
    end else begin
      start = 1'b0;
    end
    while (cyc < done_cyc) @(negedge clk);
    start = 1'b0;
    got = longint'($signed(result));
    chk(got == expv, req, got, expv);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint r, s1, s2;
    for (int i = 0; i < 256; i++) tmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !mem_rd && result == '0, "R1 in reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && result == '0, "R1 after reset", longint'(result), 0);

    // register-pair, rounded and unrounded (R7, R4, R5)
    run_op("R7 pair byte midpoint", 0, 1, 0, 16'h0080, 16'h0, 32'h10, 32'h30, 0, r);
    run_op("R4 pair byte negative unrounded", 0, 0, 0, 16'h0040, 16'h0, 32'hF0, 32'h05, 0, r);
    run_op("R5 half rounds up", 0, 1, 0, 16'h0080, 16'h0, 32'h0, 32'h1, 0, r);
    run_op("R5 negative half rounds up", 0, 1, 0, 16'h0080, 16'h0, 32'h0, 32'hFF, 0, r);
    run_op("R3 byte ignores upper bits", 0, 1, 0, 16'h0033, 16'h0, 32'hABCD_0080, 32'h1234_007F, 0, r);
    run_op("R3 word sign extension", 0, 0, 1, 16'h00C1, 16'h0, 32'h5555_8001, 32'h0000_7FFF, 0, r);
    run_op("R3 code 11 acts as long", 0, 1, 3, 16'h0010, 16'h0, 32'hFFFF_0000, 32'h0001_0000, 0, r);
    run_op("R4 long extremes unrounded", 0, 0, 2, 16'h00FF, 16'h0, 32'h7FFF_FFFF, 32'h8000_0000, 0, r);
    run_op("R5 long extremes rounded", 0, 1, 2, 16'h00FF, 16'h0, 32'h8000_0000, 32'h7FFF_FFFF, 0, r);

    // fraction zero (R6)
    run_op("R6 pair frac0 rounded", 0, 1, 1, 16'h0000, 16'h0, 32'h0000_9ABC, 32'h1, 0, r);
    run_op("R6 pair frac0 unrounded", 0, 0, 1, 16'h0000, 16'h0, 32'h0000_9ABC, 32'h1, 0, r);
    run_op("R6 table frac0 unrounded", 1, 0, 0, 16'h0700, 16'h0010, 32'h0, 32'h0, 0, r);
    run_op("R6 table frac0 rounded", 1, 1, 2, 16'h0300, 16'h0020, 32'h0, 32'h0, 0, r);

    // table mode across sizes and index wrap (R2)
    run_op("R2 table byte", 1, 1, 0, 16'h1A5C, 16'h0040, 32'h0, 32'h0, 0, r);
    run_op("R2 table word", 1, 0, 1, 16'h05E3, 16'h0003, 32'h0, 32'h0, 0, r);
    run_op("R2 table long", 1, 1, 2, 16'h0901, 16'h0011, 32'h0, 32'h0, 0, r);
    run_op("R2 table index 255", 1, 0, 1, 16'hFF7F, 16'hFFF0, 32'h0, 32'h0, 0, r);

    // start while busy is ignored (R9)
    run_op("R9 pair start while busy", 0, 1, 0, 16'h00A0, 16'h0, 32'h02, 32'h42, 1, r);
    run_op("R9 table start while busy", 1, 0, 1, 16'h0440, 16'h0008, 32'h0, 32'h0, 1, r);

    // surface chain: byte lookups into a word stage, word lookups into a long stage (R10)
    run_op("R10 column 0 byte", 1, 0, 0, 16'h0C9D, 16'h0000, 32'h0, 32'h0, 0, s1);
    run_op("R10 column 1 byte", 1, 0, 0, 16'h0C9D, 16'h0080, 32'h0, 32'h0, 0, s2);
    run_op("R10 word surface", 0, 1, 1, 16'h0057, 16'h0, 32'(s1), 32'(s2), 0, r);
    chk((r >= (s1 < s2 ? s1 : s2)) && (r <= (s1 < s2 ? s2 : s1)),
        "R10 surface within columns", r, s1);
    run_op("R10 column 0 word", 1, 0, 1, 16'h03E1, 16'h0000, 32'h0, 32'h0, 0, s1);
    run_op("R10 column 1 word", 1, 0, 1, 16'h03E1, 16'h0060, 32'h0, 32'h0, 0, s2);
    run_op("R10 long surface", 0, 1, 2, 16'h00B2, 16'h0, 32'(s1), 32'(s2), 0, r);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule